// File: doc/BRIEF.md
# Single-Step CPU Debug Panel Controller

This block sits between a board's debounced buttons and switches and a small multi-cycle CPU under test. It keeps a 3-bit mode and a 5-bit view index in registers, and turns button presses into actions. The Enter button either advances the CPU by one step or latches the switch byte as an input value, depending on the mode. The Left button cycles the mode and the Right button cycles the view index. A seven-segment driver (not part of this block) receives 16 bits of the chosen 32-bit CPU observation word.

Each mode bit has one job. The top bit selects stepping or input capture. The middle bit selects whether the memory debug address comes from the CPU or from the switches. The low bit selects whether the display shows the lower or the upper half of the selected word. The view index picks one of twelve internal CPU views. The LEDs show the mode and the index, so the operator always knows what the display shows.

Top module: `dbgp_panel`

## Requirements
- R1: After reset the mode and the view index are 0, no step or capture pulse is active, the captured byte is 0, and the display shows bits 15:0 of the program counter.
- R2: Each rising edge of the Left button adds one to the mode, wrapping from 7 to 0. A button that is held down causes no further change.
- R3: Each rising edge of the Right button adds one to the view index, wrapping from SRC_WRAP-1 to 0. A button that is held down causes no further change.
- R4: When mode bit 2 is 0 and mode bit 1 is 0, a rising edge of Enter drives `step_o` high for exactly one cycle. That cycle is the one after the clock edge that sees the press.
- R5: When mode bit 2 is 0 and mode bit 1 is 1, Enter produces no step pulse and no capture pulse.
- R6: When mode bit 2 is 1, a rising edge of Enter drives `cap_valid_o` high for one cycle and loads `sw_i` into `cap_data_o`, which then holds that value. No step pulse is produced.
- R7: `dbg_mem_addr_o` equals `cpu_mem_addr_i` when mode bit 1 is 0. It equals `sw_i` zero-extended when mode bit 1 is 1. `dbg_rf_addr_o` is always `sw_i[4:0]`.
- R8: `disp_o` shows bits 15:0 of the selected 32-bit word when mode bit 0 is 0, and bits 31:16 when mode bit 0 is 1.
- R9: View codes 0 to 7 select, in order: program counter, memory read word, instruction register, A, B, register file word at the switch address, ALU result, and the control word zero-extended to 32 bits.
- R10: View code 8 selects `dbg_mem_addr_o`. Code 9 selects the register word addressed by IR[25:21]. Code 10 selects the register word addressed by IR[20:16].
- R11: View code 11 selects a 32-bit word that is zero except for bits 4:0. Those bits hold, from bit 4 down to bit 0: memory-read, sequential, carry, overflow, zero.
- R12: Any view code of 12 or above selects `sw_i` zero-extended when mode bit 2 is 1, and zero otherwise.
- R13: `led_o[7:5]` shows the mode and `led_o[4:0]` shows the view index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, driven by the panel Reset button |
| btn_enter | input | 1 | Debounced Enter button level |
| btn_left | input | 1 | Debounced Left button level (mode cycle) |
| btn_right | input | 1 | Debounced Right button level (view cycle) |
| sw_i | input | 8 | Slide switches |
| pc_i | input | 32 | CPU program counter |
| mem_rdata_i | input | 32 | Memory word at `dbg_mem_addr_o` |
| ir_i | input | 32 | Instruction register |
| reg_a_i | input | 32 | Operand register A |
| reg_b_i | input | 32 | Operand register B |
| rf_sw_rdata_i | input | 32 | Register file word at `dbg_rf_addr_o` |
| alu_out_i | input | 32 | ALU result register |
| ctrl_word_i | input | CTRL_W | Microcode control word |
| cpu_mem_addr_i | input | ADDR_W | Memory address issued by the CPU |
| rf_rs_rdata_i | input | 32 | Register word at IR[25:21] |
| rf_rt_rdata_i | input | 32 | Register word at IR[20:16] |
| mem_rd_i | input | 1 | Memory-read flag |
| seq_i | input | 1 | Sequential-next flag |
| carry_i | input | 1 | ALU carry flag |
| ovf_i | input | 1 | ALU overflow flag |
| zero_i | input | 1 | ALU zero flag |
| step_o | output | 1 | One-cycle CPU step request |
| cap_valid_o | output | 1 | One-cycle strobe: switch byte captured |
| cap_data_o | output | 8 | Last captured switch byte |
| disp_o | output | 16 | Half word for the seven-segment driver |
| dbg_mem_addr_o | output | ADDR_W | Memory debug address |
| dbg_rf_addr_o | output | 5 | Register file debug address |
| led_o | output | 8 | Mode (7:5) and view index (4:0) |

## Verification
The bench builds two instances side by side. Both use ADDR_W=32 and CTRL_W=18. One uses the default SRC_WRAP=12 and the other uses SRC_WRAP=16. The wider instance can reach view codes 12 to 15, where the switch fallback of R12 is selected. Under the default wrap those codes never occur. Both instances are swept through all eight modes and every index reachable by Right presses. This exercises both display halves, both address sources and both Enter behaviours, with the wrap point of each index checked against arithmetic expectations.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    localparam int WORD_W  = 32;   // observation word width
    localparam int DISP_W  = 16;   // displayed half width
    localparam int SW_W    = 8;    // switch bank width
    localparam int MODE_W  = 3;    // mode register width
    localparam int IDX_W   = 5;    // view index width
    localparam int RF_AW   = 5;    // register file address width
    localparam int FLAG_W  = 5;    // status bits in the flag view
    localparam int NBTN    = 3;    // edge-detected buttons

    // mode bit roles
    localparam int MB_CAPTURE = 2;
    localparam int MB_SWADDR  = 1;
    localparam int MB_HIGH    = 0;

    // button lanes inside the edge detector
    localparam int BT_ENTER = 0;
    localparam int BT_LEFT  = 1;
    localparam int BT_RIGHT = 2;

    typedef enum logic [IDX_W-1:0] {
        VIEW_PC    = 5'd0,
        VIEW_MEM   = 5'd1,
        VIEW_IR    = 5'd2,
        VIEW_A     = 5'd3,
        VIEW_B     = 5'd4,
        VIEW_RFSW  = 5'd5,
        VIEW_ALU   = 5'd6,
        VIEW_CTRL  = 5'd7,
        VIEW_ADDR  = 5'd8,
        VIEW_RS    = 5'd9,
        VIEW_RT    = 5'd10,
        VIEW_FLAGS = 5'd11
    } view_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [IDX_W-1:0]  idx;
        logic              step;
        logic              cap;
        logic [SW_W-1:0]   cap_data;
    } panel_st_t;

endpackage

// File: rtl/dbgp_edge.sv
module dbgp_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // one rising-edge detector per button lane
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
    import dbgp_pkg::*;
#(
    parameter int SRC_WRAP = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_rise_i,
    input  logic              left_rise_i,
    input  logic              right_rise_i,
    input  logic [SW_W-1:0]   sw_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              step_o,
    output logic              cap_o,
    output logic [SW_W-1:0]   cap_data_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SRC_WRAP - 1);

    panel_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        st_d.cap  = 1'b0;

        if (left_rise_i) begin
            st_d.mode = st_q.mode + MODE_W'(1);
        end

        if (right_rise_i) begin
            st_d.idx = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + IDX_W'(1);
        end

        // decisions use the mode in force when Enter is seen
        if (enter_rise_i) begin
            if (st_q.mode[MB_CAPTURE]) begin
                st_d.cap      = 1'b1;
                st_d.cap_data = sw_i;
            end else if (!st_q.mode[MB_SWADDR]) begin
                st_d.step = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o     = st_q.mode;
    assign idx_o      = st_q.idx;
    assign step_o     = st_q.step;
    assign cap_o      = st_q.cap;
    assign cap_data_o = st_q.cap_data;

endmodule

// File: rtl/dbgp_view.sv
module dbgp_view
    import dbgp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 18
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic [WORD_W-1:0] ir_i,
    input  logic [WORD_W-1:0] reg_a_i,
    input  logic [WORD_W-1:0] reg_b_i,
    input  logic [WORD_W-1:0] rf_sw_rdata_i,
    input  logic [WORD_W-1:0] alu_out_i,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic [ADDR_W-1:0] cpu_mem_addr_i,
    input  logic [WORD_W-1:0] rf_rs_rdata_i,
    input  logic [WORD_W-1:0] rf_rt_rdata_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DISP_W-1:0] disp_o
);

    logic [WORD_W-1:0] addr_word;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] sw_word;
    logic [WORD_W-1:0] sel_word;

    // memory debug address source
    always_comb begin
        if (mode_i[MB_SWADDR]) mem_addr_o = {{(ADDR_W-SW_W){1'b0}}, sw_i};
        else                   mem_addr_o = cpu_mem_addr_i;
    end

    // fit the address to the word width, whichever is wider
    if (ADDR_W >= WORD_W) begin : g_addr_trunc
        assign addr_word = mem_addr_o[WORD_W-1:0];
    end else begin : g_addr_ext
        assign addr_word = {{(WORD_W-ADDR_W){1'b0}}, mem_addr_o};
    end

    if (CTRL_W >= WORD_W) begin : g_ctrl_trunc
        assign ctrl_word = ctrl_word_i[WORD_W-1:0];
    end else begin : g_ctrl_ext
        assign ctrl_word = {{(WORD_W-CTRL_W){1'b0}}, ctrl_word_i};
    end

    assign sw_word = mode_i[MB_CAPTURE] ? {{(WORD_W-SW_W){1'b0}}, sw_i} : '0;

    always_comb begin
        case (idx_i)
            VIEW_PC:    sel_word = pc_i;
            VIEW_MEM:   sel_word = mem_rdata_i;
            VIEW_IR:    sel_word = ir_i;
            VIEW_A:     sel_word = reg_a_i;
            VIEW_B:     sel_word = reg_b_i;
            VIEW_RFSW:  sel_word = rf_sw_rdata_i;
            VIEW_ALU:   sel_word = alu_out_i;
            VIEW_CTRL:  sel_word = ctrl_word;
            VIEW_ADDR:  sel_word = addr_word;
            VIEW_RS:    sel_word = rf_rs_rdata_i;
            VIEW_RT:    sel_word = rf_rt_rdata_i;
            VIEW_FLAGS: sel_word = {{(WORD_W-FLAG_W){1'b0}}, flags_i};
            default:    sel_word = sw_word;
        endcase
    end

    always_comb begin
        if (mode_i[MB_HIGH]) disp_o = sel_word[WORD_W-1 -: DISP_W];
        else                 disp_o = sel_word[DISP_W-1:0];
    end

endmodule

// File: rtl/dbgp_panel.sv
module dbgp_panel
    import dbgp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SRC_WRAP = 12,
    parameter int CTRL_W   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_enter,
    input  logic              btn_left,
    input  logic              btn_right,
    input  logic [7:0]        sw_i,
    input  logic [31:0]       pc_i,
    input  logic [31:0]       mem_rdata_i,
    input  logic [31:0]       ir_i,
    input  logic [31:0]       reg_a_i,
    input  logic [31:0]       reg_b_i,
    input  logic [31:0]       rf_sw_rdata_i,
    input  logic [31:0]       alu_out_i,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic [ADDR_W-1:0] cpu_mem_addr_i,
    input  logic [31:0]       rf_rs_rdata_i,
    input  logic [31:0]       rf_rt_rdata_i,
    input  logic              mem_rd_i,
    input  logic              seq_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              zero_i,
    output logic              step_o,
    output logic              cap_valid_o,
    output logic [7:0]        cap_data_o,
    output logic [15:0]       disp_o,
    output logic [ADDR_W-1:0] dbg_mem_addr_o,
    output logic [4:0]        dbg_rf_addr_o,
    output logic [7:0]        led_o
);

    logic [NBTN-1:0]   btn_lvl;
    logic [NBTN-1:0]   btn_rise;
    logic [MODE_W-1:0] mode;
    logic [IDX_W-1:0]  idx;
    logic [FLAG_W-1:0] flags;

    assign btn_lvl[BT_ENTER] = btn_enter;
    assign btn_lvl[BT_LEFT]  = btn_left;
    assign btn_lvl[BT_RIGHT] = btn_right;

    assign flags = {mem_rd_i, seq_i, carry_i, ovf_i, zero_i};

    dbgp_edge #(.N(NBTN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (btn_lvl),
        .rise_o (btn_rise)
    );

    dbgp_ctrl #(.SRC_WRAP(SRC_WRAP)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_rise_i (btn_rise[BT_ENTER]),
        .left_rise_i  (btn_rise[BT_LEFT]),
        .right_rise_i (btn_rise[BT_RIGHT]),
        .sw_i         (sw_i),
        .mode_o       (mode),
        .idx_o        (idx),
        .step_o       (step_o),
        .cap_o        (cap_valid_o),
        .cap_data_o   (cap_data_o)
    );

    dbgp_view #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_view (
        .mode_i         (mode),
        .idx_i          (idx),
        .sw_i           (sw_i),
        .pc_i           (pc_i),
        .mem_rdata_i    (mem_rdata_i),
        .ir_i           (ir_i),
        .reg_a_i        (reg_a_i),
        .reg_b_i        (reg_b_i),
        .rf_sw_rdata_i  (rf_sw_rdata_i),
        .alu_out_i      (alu_out_i),
        .ctrl_word_i    (ctrl_word_i),
        .cpu_mem_addr_i (cpu_mem_addr_i),
        .rf_rs_rdata_i  (rf_rs_rdata_i),
        .rf_rt_rdata_i  (rf_rt_rdata_i),
        .flags_i        (flags),
        .mem_addr_o     (dbg_mem_addr_o),
        .disp_o         (disp_o)
    );

    assign dbg_rf_addr_o = sw_i[RF_AW-1:0];
    assign led_o         = {mode, idx};

endmodule

// File: rtl/dbgp_panel_chk.sv
module dbgp_panel_chk #(
    parameter int ADDR_W   = 32,
    parameter int SRC_WRAP = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        sw_i,
    input logic [ADDR_W-1:0] cpu_mem_addr_i,
    input logic              step_o,
    input logic              cap_valid_o,
    input logic [7:0]        cap_data_o,
    input logic [ADDR_W-1:0] dbg_mem_addr_o,
    input logic [7:0]        led_o
);

    // R2
    mode_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o[7:5] != $past(led_o[7:5])) |-> (led_o[7:5] == $past(led_o[7:5]) + 3'd1));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({27'b0, led_o[4:0]} < SRC_WRAP));

    // R3
    idx_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o[4:0] != $past(led_o[4:0])) |->
        ((led_o[4:0] == $past(led_o[4:0]) + 5'd1) || (led_o[4:0] == 5'd0)));

    // R4
    step_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R5
    step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> ($past(led_o[7:6]) == 2'b00));

    // R6
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o |-> ($past(led_o[7]) && (cap_data_o == $past(sw_i))));

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid_o |-> $stable(cap_data_o));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_o && cap_valid_o));

    // R7
    addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_o[6] ? (dbg_mem_addr_o == {{(ADDR_W-8){1'b0}}, sw_i})
                 : (dbg_mem_addr_o == cpu_mem_addr_i));

endmodule

bind dbgp_panel dbgp_panel_chk #(.ADDR_W(ADDR_W), .SRC_WRAP(SRC_WRAP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_i           (sw_i),
    .cpu_mem_addr_i (cpu_mem_addr_i),
    .step_o         (step_o),
    .cap_valid_o    (cap_valid_o),
    .cap_data_o     (cap_data_o),
    .dbg_mem_addr_o (dbg_mem_addr_o),
    .led_o          (led_o)
);

// File: tb/dbgp_panel_tb.sv
module dbgp_panel_tb;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_enter = 1'b0, btn_left = 1'b0, btn_right = 1'b0;
    logic [7:0]  sw = 8'h00;

    logic [31:0] pc     = 32'hC0DE_0001;
    logic [31:0] memw   = 32'h8E11_0002;
    logic [31:0] ir     = 32'h2210_0004;
    logic [31:0] ra     = 32'hAAAA_1111;
    logic [31:0] rb     = 32'hBBBB_2222;
    logic [31:0] rfsw   = 32'h5555_0505;
    logic [31:0] alu    = 32'h7777_0606;
    logic [17:0] ctrl   = 18'h2_B3C5;
    logic [31:0] caddr  = 32'h1000_0030;
    logic [31:0] rs     = 32'h0909_9090;
    logic [31:0] rt     = 32'h0A0A_A0A0;
    logic [4:0]  flg    = 5'b10101;  // {mem_rd, seq, carry, ovf, zero}

    logic        step_o, cap_valid_o, step_w, cap_w;
    logic [7:0]  cap_data_o, cap_data_w, led_o, led_w;
    logic [15:0] disp_o, disp_w;
    logic [31:0] addr_o, addr_w;
    logic [4:0]  rfa_o, rfa_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cur_mode = 0;
    int idx12 = 0;
    int idx16 = 0;

    always #(CLK_NS/2) clk = ~clk;

    dbgp_panel u_dut (
        .clk(clk), .rst_n(rst_n), .btn_enter(btn_enter), .btn_left(btn_left),
        .btn_right(btn_right), .sw_i(sw), .pc_i(pc), .mem_rdata_i(memw), .ir_i(ir),
        .reg_a_i(ra), .reg_b_i(rb), .rf_sw_rdata_i(rfsw), .alu_out_i(alu),
        .ctrl_word_i(ctrl), .cpu_mem_addr_i(caddr), .rf_rs_rdata_i(rs),
        .rf_rt_rdata_i(rt), .mem_rd_i(flg[4]), .seq_i(flg[3]), .carry_i(flg[2]),
        .ovf_i(flg[1]), .zero_i(flg[0]), .step_o(step_o), .cap_valid_o(cap_valid_o),
        .cap_data_o(cap_data_o), .disp_o(disp_o), .dbg_mem_addr_o(addr_o),
        .dbg_rf_addr_o(rfa_o), .led_o(led_o)
    );

    dbgp_panel #(.SRC_WRAP(16)) u_dut_w16 (
        .clk(clk), .rst_n(rst_n), .btn_enter(btn_enter), .btn_left(btn_left),
        .btn_right(btn_right), .sw_i(sw), .pc_i(pc), .mem_rdata_i(memw), .ir_i(ir),
        .reg_a_i(ra), .reg_b_i(rb), .rf_sw_rdata_i(rfsw), .alu_out_i(alu),
        .ctrl_word_i(ctrl), .cpu_mem_addr_i(caddr), .rf_rs_rdata_i(rs),
        .rf_rt_rdata_i(rt), .mem_rd_i(flg[4]), .seq_i(flg[3]), .carry_i(flg[2]),
        .ovf_i(flg[1]), .zero_i(flg[0]), .step_o(step_w), .cap_valid_o(cap_w),
        .cap_data_o(cap_data_w), .disp_o(disp_w), .dbg_mem_addr_o(addr_w),
        .dbg_rf_addr_o(rfa_w), .led_o(led_w)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_addr(input int m, input logic [7:0] s);
        return ((m & 2) != 0) ? {24'h0, s} : caddr;
    endfunction

    function automatic logic [31:0] exp_word(input int code, input int m, input logic [7:0] s);
        case (code)
            0:  return pc;
            1:  return memw;
            2:  return ir;
            3:  return ra;
            4:  return rb;
            5:  return rfsw;
            6:  return alu;
            7:  return {14'h0, ctrl};
            8:  return exp_addr(m, s);
            9:  return rs;
            10: return rt;
            11: return {27'h0, flg};
            default: return ((m & 4) != 0) ? {24'h0, s} : 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int code);
        if (code <= 7)  return "R9";
        if (code <= 10) return "R10";
        if (code == 11) return "R11";
        return "R12";
    endfunction

    function automatic logic [15:0] half(input logic [31:0] w, input int m);
        return ((m & 1) != 0) ? w[31:16] : w[15:0];
    endfunction

    task automatic press_left();
        @(negedge clk); btn_left = 1'b1;
        @(negedge clk); btn_left = 1'b0;
        cur_mode = (cur_mode + 1) % 8;
    endtask

    task automatic press_right();
        @(negedge clk); btn_right = 1'b1;
        @(negedge clk); btn_right = 1'b0;
        idx12 = (idx12 + 1) % 12;
        idx16 = (idx16 + 1) % 16;
    endtask

    task automatic set_mode(input int target);
        while (cur_mode != target) press_left();
        chk(led_o[7:5] == 3'(target), "R2", {29'h0, led_o[7:5]}, target);
    endtask

    task automatic do_enter(input logic [7:0] s, input int exp_step, input int exp_cap,
                            input string tag);
        int ns = 0;
        int nc = 0;
        int pos = -1;
        @(negedge clk); sw = s; btn_enter = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            btn_enter = 1'b0;
            if (step_o) begin ns++; if (pos < 0) pos = c; end
            if (cap_valid_o) begin nc++; if (pos < 0) pos = c; end
        end
        chk(ns == exp_step, tag, ns, exp_step);
        chk(nc == exp_cap, tag, nc, exp_cap);
        if (exp_step + exp_cap > 0) chk(pos == 0, tag, pos, 0);
        if (exp_cap != 0) chk(cap_data_o == s, tag, {24'h0, cap_data_o}, {24'h0, s});
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(led_o == 8'h00, "R1", {24'h0, led_o}, 0);
        chk(!step_o && !cap_valid_o, "R1", {30'h0, step_o, cap_valid_o}, 0);
        chk(cap_data_o == 8'h00, "R1", {24'h0, cap_data_o}, 0);
        chk(disp_o == pc[15:0], "R1", {16'h0, disp_o}, {16'h0, pc[15:0]});

        // Sweep of all modes against every reachable index (R8..R13, R7)
        for (int m = 0; m < 8; m++) begin
            set_mode(m);
            for (int n = 0; n < 16; n++) begin
                logic [7:0] s;
                logic [31:0] w;
                @(negedge clk);
                s = 8'((n * 37) + (m * 11) + 8'h81);
                sw = s;
                #1;
                w = exp_word(idx12, m, s);
                chk(disp_o == half(w, m), tag_of(idx12), {16'h0, disp_o}, {16'h0, half(w, m)});
                w = exp_word(idx16, m, s);
                chk(disp_w == half(w, m), tag_of(idx16), {16'h0, disp_w}, {16'h0, half(w, m)});
                // R8 half selection seen on the PC view and others above
                // R13 LED contents
                chk(led_o == {3'(m), 5'(idx12)}, "R13", {24'h0, led_o}, {24'h0, 3'(m), 5'(idx12)});
                chk(led_w == {3'(m), 5'(idx16)}, "R13", {24'h0, led_w}, {24'h0, 3'(m), 5'(idx16)});
                // R7 address sources
                chk(addr_o == exp_addr(m, s), "R7", addr_o, exp_addr(m, s));
                chk(rfa_o == s[4:0], "R7", {27'h0, rfa_o}, {27'h0, s[4:0]});
                press_right();
            end
        end

        // R3 wrap point of the default instance: go to index 11, then one more
        while (idx12 != 11) press_right();
        chk(led_o[4:0] == 5'd11, "R3", {27'h0, led_o[4:0]}, 11);
        press_right();
        chk(led_o[4:0] == 5'd0, "R3", {27'h0, led_o[4:0]}, 0);

        // R2 wrap from 7 to 0
        set_mode(7);
        press_left();
        chk(led_o[7:5] == 3'd0, "R2", {29'h0, led_o[7:5]}, 0);

        // R2 held Left counts once
        @(negedge clk); btn_left = 1'b1;
        repeat (6) @(negedge clk);
        btn_left = 1'b0;
        cur_mode = (cur_mode + 1) % 8;
        chk(led_o[7:5] == 3'd1, "R2", {29'h0, led_o[7:5]}, 1);

        // R3 held Right counts once
        @(negedge clk); btn_right = 1'b1;
        repeat (6) @(negedge clk);
        btn_right = 1'b0;
        idx12 = (idx12 + 1) % 12;
        idx16 = (idx16 + 1) % 16;
        chk(led_o[4:0] == 5'(idx12), "R3", {27'h0, led_o[4:0]}, idx12);

        // R4 step in modes 0 and 1
        set_mode(0);
        do_enter(8'h3C, 1, 0, "R4");
        set_mode(1);
        do_enter(8'h4D, 1, 0, "R4");
        // R5 suppressed in modes 2 and 3
        set_mode(2);
        do_enter(8'h5E, 0, 0, "R5");
        set_mode(3);
        do_enter(8'h6F, 0, 0, "R5");
        // R6 capture in modes 4..7
        for (int m = 4; m < 8; m++) begin
            set_mode(m);
            do_enter(8'(8'h90 + m * 13), 0, 1, "R6");
        end
        // R6 captured byte holds after switches move
        @(negedge clk); sw = 8'h00; #1;
        chk(cap_data_o == 8'(8'h90 + 7 * 13), "R6", {24'h0, cap_data_o}, {24'h0, 8'(8'h90 + 7 * 13)});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule